// File: doc/BRIEF.md
# ADC control and result formatter

This block is the register-side wrapper of a successive-approximation converter core. Software writes one control byte that carries a reference choice, a result-alignment bit and an input-channel number. The block forwards the reference and the channel to the core. It takes each finished conversion as a signed 12-bit value, clamps that value to a 10-bit two's-complement code and stores it. It returns the stored code as two bytes, packed toward the top or toward the bottom of the 16-bit pair.

The core signals the start and the end of each conversion with single-cycle pulses. A reference change never reaches the core in the middle of a conversion; it is applied when the conversion ends. A channel change takes effect at the next start pulse. The alignment bit acts on the stored code alone, so flipping it changes the two result bytes at once, even while a conversion is running. A sticky done flag records each finished conversion until software clears it.

Top module: `adc_fmt_ctrl`

## Requirements
- R1: After reset, every register reads 0 at every address, and both `ref_sel_o` and `chan_o` are 0.
- R2: Address 0 is the control byte and reads back exactly as written. Its fields are reference select in bits 7:6, alignment in bit 5 (1 = left) and channel in bits 4:0.
- R3: While a conversion is in progress, `ref_sel_o` holds its value. A pending reference value is applied on the clock edge at which the done pulse is sampled.
- R4: While idle, a reference write reaches `ref_sel_o` one clock after the control byte updates.
- R5: Reference code 2'b10 is reserved. It reads back as written at address 0, but `ref_sel_o` keeps its previous value. Codes 00, 01 and 11 select the external pin, the analog supply and the internal reference.
- R6: The 12-bit signed input is clamped to the range -512..+511. Anything at +512 or above is stored as 0x1FF, and anything at -513 or below is stored as 0x200. Values inside the range are stored as their low 10 bits.
- R7: With alignment 1, address 3 returns code bits 9:2. Address 2 returns code bits 1:0 in its bits 7:6 and zeros below them. A code of -400 (0x270) reads 0x9C at address 3 and 0x00 at address 2.
- R8: With alignment 0, address 2 returns code bits 7:0. Address 3 returns code bits 9:8 in its bits 1:0 and zeros above them. A code of 0x270 reads 0x70 at address 2 and 0x02 at address 3.
- R9: A write to the alignment bit changes the result bytes in the cycle after the write, including during a conversion. The stored code itself does not change.
- R10: Status bit 0 (address 1) is set by a done pulse and cleared by writing 1 to it. Writing 0 to it has no effect. If a done pulse and a clearing write occur in the same cycle, the bit is set.
- R11: `chan_o` loads the channel field only on a start pulse. A channel write between start pulses leaves `chan_o` unchanged.
- R12: Status bit 1 reads 1 from the edge that samples a start pulse until the edge that samples the done pulse. If both pulses occur in the same cycle, the start pulse wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, already synchronized on release |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 status, 2 result low, 3 result high |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| conv_start | input | 1 | One-cycle pulse: the core begins a conversion |
| conv_done | input | 1 | One-cycle pulse: `conv_result` is valid |
| conv_result | input | 12 | Signed conversion value from the core |
| ref_sel_o | output | 2 | Reference currently applied to the core |
| chan_o | output | 5 | Channel latched for the current conversion |

## Verification
The hardest state to reach from the ports is a reference write that arrives in the middle of a conversion, followed by a done pulse. The bench must show that the old reference holds for several cycles and that the new one appears exactly on the edge after done. To get there, the stimulus issues a start pulse, then writes a new reference, a new alignment and a new channel while the core is still busy. It reads the result bytes and the status during the busy window and only then delivers the done pulse. A second sequence places a clearing write to the done flag in the same cycle as a done pulse, to exercise the set-wins rule.

// File: rtl/adcf_pkg.sv
package adcf_pkg;
  localparam int BYTE_W = 8;
  localparam int CHAN_W = 5;
  localparam int ADDR_W = 2;

  typedef enum logic [1:0] {
    REF_EXT_PIN    = 2'b00,
    REF_ANA_SUPPLY = 2'b01,
    REF_RESERVED   = 2'b10,
    REF_INTERNAL   = 2'b11
  } ref_sel_e;

  typedef struct packed {
    ref_sel_e            ref_sel;
    logic                left_adj;
    logic [CHAN_W-1:0]   chan;
  } ctrl_t;

  localparam logic [ADDR_W-1:0] A_CTRL   = 2'd0;
  localparam logic [ADDR_W-1:0] A_STAT   = 2'd1;
  localparam logic [ADDR_W-1:0] A_RES_LO = 2'd2;
  localparam logic [ADDR_W-1:0] A_RES_HI = 2'd3;

  localparam int ST_DONE_BIT = 0;
  localparam int ST_BUSY_BIT = 1;
endpackage

// File: rtl/adcf_sat.sv
// Clamp a wide signed sample into a narrower two's-complement code.
module adcf_sat #(
  parameter int IN_W  = 12,
  parameter int RES_W = 10
) (
  input  logic signed [IN_W-1:0]  din,
  output logic        [RES_W-1:0] dout
);
  localparam int HI_I = (1 << (RES_W-1)) - 1;
  localparam int LO_I = -(1 << (RES_W-1));
  localparam logic signed [IN_W-1:0] HI_S = HI_I[IN_W-1:0];
  localparam logic signed [IN_W-1:0] LO_S = LO_I[IN_W-1:0];

  always_comb begin
    if (din > HI_S)      dout = HI_S[RES_W-1:0];
    else if (din < LO_S) dout = LO_S[RES_W-1:0];
    else                 dout = din[RES_W-1:0];
  end
endmodule

// File: rtl/adcf_fmt.sv
// Places the stored code at the top or bottom of a byte pair.
module adcf_fmt #(
  parameter int RES_W = 10
) (
  input  logic [RES_W-1:0] code,
  input  logic             left_adj,
  output logic [7:0]       lo_byte,
  output logic [7:0]       hi_byte
);
  localparam int PAIR_W = 16;
  localparam int PAD_W  = PAIR_W - RES_W;

  logic [PAIR_W-1:0] pair;

  always_comb begin
    if (left_adj) pair = {code, {PAD_W{1'b0}}};
    else          pair = {{PAD_W{1'b0}}, code};
  end

  assign lo_byte = pair[7:0];
  assign hi_byte = pair[PAIR_W-1:8];
endmodule

// File: rtl/adcf_regs.sv
// Control byte and sticky done flag.
module adcf_regs
  import adcf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  input  logic              conv_done,
  output ctrl_t             ctrl_q,
  output logic              done_q
);
  logic  ctrl_en;
  logic  done_en;
  logic  done_d;
  ctrl_t ctrl_d;

  always_comb begin
    ctrl_en = reg_wr && (reg_addr == A_CTRL);
    ctrl_d  = ctrl_t'(reg_wdata);
    done_en = conv_done || (reg_wr && (reg_addr == A_STAT) && reg_wdata[ST_DONE_BIT]);
    done_d  = conv_done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      done_q <= 1'b0;
    end else begin
      if (ctrl_en) ctrl_q <= ctrl_d;
      if (done_en) done_q <= done_d;
    end
  end
endmodule

// File: rtl/adcf_conv_track.sv
// Tracks the conversion in flight, gates the reference, latches channel and code.
module adcf_conv_track
  import adcf_pkg::*;
#(
  parameter int IN_W  = 12,
  parameter int RES_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrl_t             ctrl_q,
  input  logic              conv_start,
  input  logic              conv_done,
  input  logic [IN_W-1:0]   conv_result,
  output logic              busy_q,
  output ref_sel_e          ref_q,
  output logic [CHAN_W-1:0] chan_q,
  output logic [RES_W-1:0]  res_q
);
  logic             ref_en;
  logic             busy_en;
  logic             busy_d;
  logic [RES_W-1:0] sat_code;

  adcf_sat #(.IN_W(IN_W), .RES_W(RES_W)) u_sat (
    .din  ($signed(conv_result)),
    .dout (sat_code)
  );

  always_comb begin
    ref_en  = (!busy_q || conv_done) && (ctrl_q.ref_sel != REF_RESERVED);
    busy_en = conv_start || conv_done;
    busy_d  = conv_start;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ref_q  <= REF_EXT_PIN;
      chan_q <= '0;
      res_q  <= '0;
    end else begin
      if (busy_en)    busy_q <= busy_d;
      if (ref_en)     ref_q  <= ctrl_q.ref_sel;
      if (conv_start) chan_q <= ctrl_q.chan;
      if (conv_done)  res_q  <= sat_code;
    end
  end
endmodule

// File: rtl/adc_fmt_ctrl.sv
module adc_fmt_ctrl
  import adcf_pkg::*;
#(
  parameter int IN_W  = 12,
  parameter int RES_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              conv_start,
  input  logic              conv_done,
  input  logic [IN_W-1:0]   conv_result,
  output logic [1:0]        ref_sel_o,
  output logic [4:0]        chan_o
);
  ctrl_t             ctrl_q;
  logic              done_q;
  logic              busy_q;
  ref_sel_e          ref_q;
  logic [CHAN_W-1:0] chan_q;
  logic [RES_W-1:0]  res_q;
  logic [7:0]        lo_byte;
  logic [7:0]        hi_byte;
  logic [7:0]        stat_byte;

  adcf_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .conv_done (conv_done),
    .ctrl_q    (ctrl_q),
    .done_q    (done_q)
  );

  adcf_conv_track #(.IN_W(IN_W), .RES_W(RES_W)) u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl_q      (ctrl_q),
    .conv_start  (conv_start),
    .conv_done   (conv_done),
    .conv_result (conv_result),
    .busy_q      (busy_q),
    .ref_q       (ref_q),
    .chan_q      (chan_q),
    .res_q       (res_q)
  );

  adcf_fmt #(.RES_W(RES_W)) u_fmt (
    .code     (res_q),
    .left_adj (ctrl_q.left_adj),
    .lo_byte  (lo_byte),
    .hi_byte  (hi_byte)
  );

  always_comb begin
    stat_byte              = '0;
    stat_byte[ST_DONE_BIT] = done_q;
    stat_byte[ST_BUSY_BIT] = busy_q;
    case (reg_addr)
      A_CTRL:   reg_rdata = ctrl_q;
      A_STAT:   reg_rdata = stat_byte;
      A_RES_LO: reg_rdata = lo_byte;
      default:  reg_rdata = hi_byte;
    endcase
  end

  assign ref_sel_o = ref_q;
  assign chan_o    = chan_q;
endmodule

// File: rtl/adcf_chk.sv
module adcf_chk #(
  parameter int IN_W  = 12,
  parameter int RES_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [1:0]       reg_addr,
  input logic             wdata0,
  input logic             conv_start,
  input logic             conv_done,
  input logic [IN_W-1:0]  conv_result,
  input logic [1:0]       ref_sel_o,
  input logic [4:0]       chan_o,
  input logic             busy_q,
  input logic             done_q,
  input logic [RES_W-1:0] res_q
);
  localparam int HI_I = (1 << (RES_W-1)) - 1;
  localparam int LO_I = -(1 << (RES_W-1));
  localparam logic signed [IN_W-1:0] HI_S = HI_I[IN_W-1:0];
  localparam logic signed [IN_W-1:0] LO_S = LO_I[IN_W-1:0];

  // R3
  ref_hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !conv_done) |=> $stable(ref_sel_o));

  // R5
  ref_never_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_sel_o != 2'b10);

  // R11
  chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_start |=> $stable(chan_o));

  // R10
  done_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> done_q);

  // R10
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd1 && wdata0 && !conv_done) |=> !done_q);

  // R6
  sat_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && ($signed(conv_result) > HI_S)) |=> (res_q == HI_S[RES_W-1:0]));

  // R6
  sat_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && ($signed(conv_result) < LO_S)) |=> (res_q == LO_S[RES_W-1:0]));

  // R12
  busy_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> busy_q);
endmodule

bind adc_fmt_ctrl adcf_chk #(.IN_W(IN_W), .RES_W(RES_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr      (reg_wr),
  .reg_addr    (reg_addr),
  .wdata0      (reg_wdata[0]),
  .conv_start  (conv_start),
  .conv_done   (conv_done),
  .conv_result (conv_result),
  .ref_sel_o   (ref_sel_o),
  .chan_o      (chan_o),
  .busy_q      (busy_q),
  .done_q      (done_q),
  .res_q       (res_q)
);

// File: tb/adc_fmt_ctrl_test.sv
`timescale 1ns/100ps
module adc_fmt_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [7:0]  reg_wdata = 8'd0;
  logic [7:0]  reg_rdata;
  logic        conv_start = 1'b0;
  logic        conv_done = 1'b0;
  logic [11:0] conv_result = 12'd0;
  logic [1:0]  ref_sel_o;
  logic [4:0]  chan_o;

  int checks = 0;
  int errors = 0;
  bit ended  = 1'b0;

  // behavioural reference state
  logic [7:0] m_ctrl;
  logic [9:0] m_res;
  logic       m_done, m_busy;
  logic [1:0] m_ref;
  logic [4:0] m_chan;

  adc_fmt_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .conv_start(conv_start),
    .conv_done(conv_done), .conv_result(conv_result),
    .ref_sel_o(ref_sel_o), .chan_o(chan_o)
  );

  always #2 clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] res_byte(logic [9:0] r, logic left, logic hi);
    logic [15:0] w;
    w = left ? {r, 6'b0} : {6'b0, r};
    return hi ? w[15:8] : w[7:0];
  endfunction

  function automatic logic [7:0] exp_rdata(logic [1:0] a);
    case (a)
      2'd0:    return m_ctrl;
      2'd1:    return {6'b0, m_busy, m_done};
      2'd2:    return res_byte(m_res, m_ctrl[5], 1'b0);
      default: return res_byte(m_res, m_ctrl[5], 1'b1);
    endcase
  endfunction

  // reference model, advanced on each rising edge from the inputs of that cycle
  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 8'd0; m_res = 10'd0; m_done = 1'b0; m_busy = 1'b0;
      m_ref = 2'd0; m_chan = 5'd0;
    end else begin
      int v;
      if ((!m_busy || conv_done) && m_ctrl[7:6] != 2'b10) m_ref = m_ctrl[7:6];
      if (conv_start) m_chan = m_ctrl[4:0];
      if (conv_done) begin
        v = $signed(conv_result);
        if (v > 511) v = 511;
        if (v < -512) v = -512;
        m_res = v[9:0];
      end
      if (conv_start) m_busy = 1'b1;
      else if (conv_done) m_busy = 1'b0;
      if (conv_done) m_done = 1'b1;
      else if (reg_wr && reg_addr == 2'd1 && reg_wdata[0]) m_done = 1'b0;
      if (reg_wr && reg_addr == 2'd0) m_ctrl = reg_wdata;
    end
  end

  // every-cycle comparison, late in the cycle
  always @(negedge clk) begin
    #1.5;
    if (rst_n && !ended) begin
      chk("R2/R5/R7/R8/R10/R12 rdata", reg_rdata, exp_rdata(reg_addr));
      chk("R3/R4/R5 ref_sel_o", ref_sel_o, m_ref);
      chk("R11 chan_o", chan_o, m_chan);
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask
  task automatic wr(logic [1:0] a, logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; step(); reg_wr = 1'b0;
  endtask
  task automatic rd(logic [1:0] a, logic [7:0] e, string tag);
    reg_addr = a; #0.5; chk(tag, reg_rdata, e); step();
  endtask
  task automatic chk_ref(logic [1:0] e, string tag);
    #0.2; chk(tag, ref_sel_o, e);
  endtask
  task automatic start_pulse();
    conv_start = 1'b1; step(); conv_start = 1'b0;
  endtask
  task automatic done_pulse(int v);
    conv_done = 1'b1; conv_result = v[11:0]; step(); conv_done = 1'b0;
  endtask
  task automatic sat_case(int v, logic [9:0] code, logic left);
    start_pulse(); step(); done_pulse(v);
    rd(2'd2, res_byte(code, left, 1'b0), "R6 low byte");
    rd(2'd3, res_byte(code, left, 1'b1), "R6 high byte");
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #800000;
    checks++; errors++;
    $display("FAIL watchdog: run did not complete, actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset values
    chk("R1 ref_sel_o", ref_sel_o, 0);
    chk("R1 chan_o", chan_o, 0);
    for (int a = 0; a < 4; a++) rd(a[1:0], 8'h00, "R1 register");

    // R2 / R4: ref=11, left, chan=13
    wr(2'd0, 8'hED);
    chk_ref(2'b00, "R4 not yet applied");
    step();
    chk_ref(2'b11, "R4 applied one clock later");
    rd(2'd0, 8'hED, "R2 control readback");

    // R7: -400 left adjusted
    start_pulse();
    chk("R11 channel latched on start", chan_o, 13);
    step(); step();
    done_pulse(-400);
    rd(2'd2, 8'h00, "R7 low byte");
    rd(2'd3, 8'h9C, "R7 high byte");
    rd(2'd1, 8'h01, "R10/R12 status after done");

    // R8 / R9: switch to right adjust
    wr(2'd0, 8'hCD);
    rd(2'd2, 8'h70, "R9 immediate low byte");
    rd(2'd3, 8'h02, "R8 high byte");

    // R3 / R9 / R11 / R12: writes during busy
    start_pulse();
    wr(2'd0, 8'h6A);
    rd(2'd3, 8'h9C, "R9 reformat while busy");
    rd(2'd1, 8'h03, "R12 busy bit set");
    chk_ref(2'b11, "R3 reference held while busy");
    step(); step();
    chk_ref(2'b11, "R3 reference still held");
    chk("R11 channel unchanged mid-conversion", chan_o, 13);
    done_pulse(100);
    chk_ref(2'b01, "R3 pending reference applied at done");
    rd(2'd1, 8'h01, "R12 busy cleared");
    start_pulse();
    chk("R11 new channel on next start", chan_o, 10);
    done_pulse(0);

    // R6 saturation, left adjusted
    sat_case(511, 10'h1FF, 1'b1);
    sat_case(512, 10'h1FF, 1'b1);
    sat_case(2047, 10'h1FF, 1'b1);
    sat_case(-512, 10'h200, 1'b1);
    sat_case(-513, 10'h200, 1'b1);
    sat_case(-2048, 10'h200, 1'b1);
    sat_case(-1, 10'h3FF, 1'b1);

    // R5 reserved reference code
    wr(2'd0, 8'hAA);
    rd(2'd0, 8'hAA, "R5 reserved code reads back");
    step(); step();
    chk_ref(2'b01, "R5 reserved code not applied");
    wr(2'd0, 8'h00);
    step();
    chk_ref(2'b00, "R4 external pin reference");

    // R10 sticky done flag
    wr(2'd1, 8'h00);
    rd(2'd1, 8'h01, "R10 write 0 no effect");
    wr(2'd1, 8'h01);
    rd(2'd1, 8'h00, "R10 write 1 clears");
    start_pulse();
    reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 8'h01;
    conv_done = 1'b1; conv_result = 12'd5;
    step();
    reg_wr = 1'b0; conv_done = 1'b0;
    rd(2'd1, 8'h01, "R10 set wins over clear");

    // R12 start and done in the same cycle
    conv_start = 1'b1; conv_done = 1'b1; conv_result = 12'd7;
    step();
    conv_start = 1'b0; conv_done = 1'b0;
    rd(2'd1, 8'h03, "R12 start wins over done");
    done_pulse(9);
    step();
    finish_run();
  end
endmodule